// File: doc/BRIEF.md
# Synchronous Burst Static RAM Core

This block is a cycle-accurate, synthesizable model of a synchronous burst static RAM. Its depth is set by a parameter and kept small. A host starts an access by pulling one of two address strobes low while all three chip-select inputs are in their selecting state. On the following clock edges the block serves up to four consecutive words of an aligned group of four. An internal 2-bit burst counter steps under a step input. The two strobes differ in when write data is taken. The late strobe takes it one edge after the address. The early strobe takes it on the same edge as the address.

Words are 18 bits wide and form two 9-bit lanes, each made of a data byte and a parity bit. A write covers either the whole word or any chosen set of lanes. The `PIPELINED` parameter selects the read timing. Flow-through timing gives 2-1-1-1 reads. Pipelined timing adds one register and gives 3-1-1-1 reads. The output driver is modelled as a drive-enable signal plus a data bus.

The controller is a two-state machine. **ST_IDLE** holds no burst. It moves to **ST_BURST** on a selected strobe edge (transition *start*). In **ST_BURST** there are three transitions:
- A selected strobe edge restarts the burst at a new address (*restart*).
- An edge with both strobes high continues the burst at the held or stepped address (*continue*).
- An edge where a strobe is low but the chip is not selected returns to ST_IDLE (*deselect*).

Top module: `sburst_sram`

## Requirements
- R1: An edge with either strobe low while the chip is not selected stores nothing and ends any burst. The chip is selected only when `sel_n`=0, `sel2_n`=0 and `sel3`=1. Edges after it with both strobes high neither read nor write until the next selected strobe edge.
- R2: On an edge where a strobe is low and the chip is selected, `addr` is captured as the burst address. When no write occurs on that edge, the word at that address is read.
- R3: An edge started by `estrb_n` alone writes `wdata` to `addr` on that same edge, if a write enable is active.
- R4: An edge started by `lstrb_n` never writes, whatever the write enables show. Its write data is taken on the next edge (a continue edge with `step_n`=1) at the captured address.
- R5: On a continue edge the burst address steps by one when `step_n`=0 and holds when `step_n`=1. That edge's read or write uses the resulting address.
- R6: Stepping changes only the two low address bits and wraps from 3 to 0. For example, a start at 0x0A steps to 0x0B, 0x08, 0x09, 0x0A.
- R7: A read on clock edge k drives its word in the cycle after edge k with flow-through timing (`PIPELINED`=0). With pipelined timing (`PIPELINED`=1) the word is driven one cycle later.
- R8: The word layout is bit 17 = parity 2, bits 16:9 = data [15:8], bit 8 = parity 1, bits 7:0 = data [7:0]. Lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R9: `wr_all_n`=0 writes both lanes, whatever `lane_wr_n` and `lane_mask_n` show.
- R10: With `wr_all_n`=1 and `lane_wr_n`=0, lane i is written only when `lane_mask_n[i]`=0. With `lane_mask_n`=11, or with `lane_wr_n`=1, the edge is a read and nothing is written.
- R11: `rdata_drv` is 1 only when `out_en_n`=0 and a read's word is due in that cycle. While `rdata_drv` is 0, `rdata` is zero.
- R12: When both strobes are low on a selected edge, `lstrb_n` wins and that edge stores nothing, even with write enables active.
- R13: While `rst_n` is low, and after it, until the first read is due, `rdata_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address captured on a strobe edge |
| lstrb_n | input | 1 | Late-data address strobe, active low, has priority |
| estrb_n | input | 1 | Early-data address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| sel_n | input | 1 | Chip select, active low |
| sel2_n | input | 1 | Second chip select, active low |
| sel3 | input | 1 | Third chip select, active high |
| wr_all_n | input | 1 | Whole-word write enable, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_mask_n | input | 2 | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low |
| wdata | input | 18 | Write word |
| rdata | output | 18 | Read word, zero while not driven |
| rdata_drv | output | 1 | Output drive enable |

## Verification
The assertions check on every cycle the rules that need no memory contents:
- no store on a deselected strobe edge, and none on a late-strobe edge;
- an early-strobe write lands on its own edge;
- the address holds while the step input is high, and stepping never leaves its group of four;
- drive is never on without the output enable, or without a read issued the right number of cycles earlier;
- a whole-word write reaches both lanes.

Only the bench scenarios can show that the right word comes back. These cover wrap order, suspended bursts, which lane bytes a masked write changed, that words survive deselected and conflicting strobes, and the single extra cycle of pipelined timing. They use a pipelined instance and a flow-through instance run side by side.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;
endpackage

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6   // must be at least 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lstrb_n,
    input  logic              estrb_n,
    input  logic              step_n,
    input  logic              sel_n,
    input  logic              sel2_n,
    input  logic              sel3,
    input  logic              wr_any,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_fire,
    output logic              rd_fire
);
    burst_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              chip_sel, strobe, start, late_start;

    assign chip_sel   = ~sel_n & ~sel2_n & sel3;
    assign strobe     = ~lstrb_n | ~estrb_n;
    assign start      = strobe & chip_sel;
    assign late_start = start & ~lstrb_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        acc_addr = addr_q;
        wr_fire  = 1'b0;
        rd_fire  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_BURST;
                    addr_d   = addr;
                    acc_addr = addr;
                    wr_fire  = ~late_start & wr_any;
                    rd_fire  = ~(~late_start & wr_any);
                end
            end
            ST_BURST: begin
                if (start) begin
                    addr_d   = addr;
                    acc_addr = addr;
                    wr_fire  = ~late_start & wr_any;
                    rd_fire  = ~(~late_start & wr_any);
                end else if (strobe) begin
                    state_d = ST_IDLE;
                end else begin
                    addr_d   = {addr_q[ADDR_W-1:2], addr_q[1:0] + {1'b0, ~step_n}};
                    acc_addr = addr_d;
                    wr_fire  = wr_any;
                    rd_fire  = ~wr_any;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_UNSEL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !chip_sel) |-> !wr_fire); // R1

    AST_EARLY_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && lstrb_n && wr_any) |-> (wr_fire && acc_addr == addr)); // R3

    AST_LATE_NO_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !lstrb_n) |-> !wr_fire); // R4

    AST_HOLD_ON_STEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !strobe && step_n) |=> $stable(addr_q)); // R5

    AST_STAY_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !strobe) |-> acc_addr[ADDR_W-1:2] == addr_q[ADDR_W-1:2]); // R6
endmodule

// File: rtl/sburst_lane_bank.sv
module sburst_lane_bank #(
    parameter int ADDR_W = 6,
    parameter int W      = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/sburst_out_stage.sv
module sburst_out_stage #(
    parameter bit PIPELINED = 1'b1,
    parameter int W         = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_fire,
    input  logic [W-1:0] bank_data,
    input  logic         out_en_n,
    output logic [W-1:0] rdata,
    output logic         rdata_drv
);
    localparam int LAT = PIPELINED ? 2 : 1;

    logic         v1_q;
    logic         valid;
    logic [W-1:0] data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v1_q <= 1'b0;
        else        v1_q <= rd_fire;
    end

    generate
        if (PIPELINED) begin : g_pipe
            logic         v2_q;
            logic [W-1:0] d2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v2_q <= 1'b0;
                    d2_q <= '0;
                end else begin
                    v2_q <= v1_q;
                    d2_q <= bank_data;
                end
            end
            assign valid = v2_q;
            assign data  = d2_q;
        end else begin : g_flow
            assign valid = v1_q;
            assign data  = bank_data;
        end
    endgenerate

    assign rdata_drv = valid & ~out_en_n;
    assign rdata     = rdata_drv ? data : '0;

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drv |-> !out_en_n); // R11

    AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drv |-> $past(rd_fire, LAT)); // R7
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter bit PIPELINED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lstrb_n,
    input  logic              estrb_n,
    input  logic              step_n,
    input  logic              sel_n,
    input  logic              sel2_n,
    input  logic              sel3,
    input  logic              wr_all_n,
    input  logic              lane_wr_n,
    input  logic [1:0]        lane_mask_n,
    input  logic              out_en_n,
    input  logic [17:0]       wdata,
    output logic [17:0]       rdata,
    output logic              rdata_drv
);
    logic [ADDR_W-1:0] acc_addr;
    logic              wr_fire, rd_fire, wr_any;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] bank_word;

    assign wr_any = ~wr_all_n | (~lane_wr_n & ~(&lane_mask_n));

    sburst_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .lstrb_n(lstrb_n), .estrb_n(estrb_n), .step_n(step_n),
        .sel_n(sel_n), .sel2_n(sel2_n), .sel3(sel3),
        .wr_any(wr_any), .acc_addr(acc_addr),
        .wr_fire(wr_fire), .rd_fire(rd_fire)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_we[i] = wr_fire & (~wr_all_n | (~lane_wr_n & ~lane_mask_n[i]));
            sburst_lane_bank #(.ADDR_W(ADDR_W), .W(LANE_W)) bank_i (
                .clk(clk), .we(lane_we[i]), .addr(acc_addr),
                .wdata(wdata[i*LANE_W +: LANE_W]),
                .rdata(bank_word[i*LANE_W +: LANE_W])
            );
        end
    endgenerate

    sburst_out_stage #(.PIPELINED(PIPELINED), .W(WORD_W)) out_i (
        .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire),
        .bank_data(bank_word), .out_en_n(out_en_n),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    AST_WHOLE_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !wr_all_n) |-> (&lane_we)); // R9

    AST_NO_LANE_WITHOUT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |-> (lane_we == '0)); // R10
endmodule

// File: tb/sburst_sram_tb_top.sv
`timescale 1ns/1ps
module sburst_sram_tb_top;
    localparam int AW = 6;
    localparam logic [2:0] SEL = 3'b001;   // {sel_n, sel2_n, sel3}

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] addr;
    logic          lstrb_n, estrb_n, step_n, sel_n, sel2_n, sel3;
    logic          wr_all_n, lane_wr_n, out_en_n;
    logic [1:0]    lane_mask_n;
    logic [17:0]   wdata;
    logic [17:0]   rd_p, rd_f;
    logic          en_p, en_f;

    sburst_sram #(.ADDR_W(AW), .PIPELINED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .lstrb_n(lstrb_n), .estrb_n(estrb_n),
        .step_n(step_n), .sel_n(sel_n), .sel2_n(sel2_n), .sel3(sel3),
        .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_mask_n(lane_mask_n),
        .out_en_n(out_en_n), .wdata(wdata), .rdata(rd_p), .rdata_drv(en_p));

    sburst_sram #(.ADDR_W(AW), .PIPELINED(1'b0)) dut_ft_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .lstrb_n(lstrb_n), .estrb_n(estrb_n),
        .step_n(step_n), .sel_n(sel_n), .sel2_n(sel2_n), .sel3(sel3),
        .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_mask_n(lane_mask_n),
        .out_en_n(out_en_n), .wdata(wdata), .rdata(rd_f), .rdata_drv(en_f));

    typedef struct packed {
        logic        v;
        logic [17:0] d;
    } exp_t;

    exp_t    qp[$], qf[$];
    string   tp[$], tf[$];
    string   cur_tag;
    int      errs = 0, checks = 0;
    bit      mon_on = 0, fin = 0;
    logic [17:0]   mm [1 << AW];
    logic          m_act = 1'b0;
    logic [AW-1:0] m_addr = '0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // driver: one clock edge of stimulus, reference model, queue push
    task automatic cyc(logic [AW-1:0] a, logic ls_n, logic es_n, logic sp_n, logic [2:0] ch,
                       logic wa_n, logic lw_n, logic [1:0] lm_n, logic oe_v, logic [17:0] d);
        logic sel, strb, st, ps, wa, wr, rd;
        logic [AW-1:0] acc;
        exp_t e;
        addr = a; lstrb_n = ls_n; estrb_n = es_n; step_n = sp_n;
        {sel_n, sel2_n, sel3} = ch;
        wr_all_n = wa_n; lane_wr_n = lw_n; lane_mask_n = lm_n; out_en_n = oe_v; wdata = d;
        @(posedge clk);
        sel  = !ch[2] && !ch[1] && ch[0];
        strb = !ls_n || !es_n;
        st   = strb && sel;
        ps   = st && !ls_n;
        wa   = !wa_n || (!lw_n && lm_n != 2'b11);
        wr = 1'b0; rd = 1'b0; acc = m_addr;
        if (st) begin
            m_act = 1'b1; m_addr = a; acc = a;
            wr = !ps && wa; rd = !wr;
        end else if (strb) begin
            m_act = 1'b0;
        end else if (m_act) begin
            m_addr[1:0] = m_addr[1:0] + {1'b0, !sp_n};
            acc = m_addr; wr = wa; rd = !wa;
        end
        e.v = rd;
        e.d = mm[acc];
        if (wr) begin
            if (!wa_n || (!lw_n && !lm_n[0])) mm[acc][8:0]  = d[8:0];
            if (!wa_n || (!lw_n && !lm_n[1])) mm[acc][17:9] = d[17:9];
        end
        qf.push_back(e); tf.push_back(cur_tag);
        qp.push_back(e); tp.push_back(cur_tag);
        @(negedge clk);
    endtask

    task automatic nop(logic oe_v);
        cyc('0, 1, 1, 1, SEL, 1, 1, 2'b11, oe_v, '0);
    endtask

    task automatic stp(logic oe_v);
        cyc('0, 1, 1, 0, SEL, 1, 1, 2'b11, oe_v, '0);
    endtask

    task automatic rd_start(logic [AW-1:0] a);
        cyc(a, 0, 1, 1, SEL, 1, 1, 2'b11, 0, '0);
    endtask

    task automatic early_wr(logic [AW-1:0] a, logic [17:0] d);
        cyc(a, 1, 0, 1, SEL, 0, 1, 2'b11, 1, d);
    endtask

    // monitor: pops one expected item per cycle for each instance
    initial begin
        exp_t  e;
        string t;
        logic  x;
        wait (mon_on);
        forever begin
            @(posedge clk);
            #4;
            if (qf.size() > 0) begin
                e = qf.pop_front(); t = tf.pop_front();
                x = e.v && !out_en_n;
                check(t, "flow drive", {31'b0, en_f}, {31'b0, x});
                check(t, "flow data", {14'b0, rd_f}, x ? {14'b0, e.d} : 32'b0);
            end
            if (qp.size() > 0) begin
                e = qp.pop_front(); t = tp.pop_front();
                x = e.v && !out_en_n;
                check(t, "pipe drive", {31'b0, en_p}, {31'b0, x});
                check(t, "pipe data", {14'b0, rd_p}, x ? {14'b0, e.d} : 32'b0);
            end
        end
    end

    initial begin
        #2000000;
        if (!fin) begin
            errs++;
            $display("FAIL R2 watchdog act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; lstrb_n = 1; estrb_n = 1; step_n = 1;
        {sel_n, sel2_n, sel3} = SEL; wr_all_n = 1; lane_wr_n = 1; lane_mask_n = 2'b11;
        out_en_n = 0; wdata = '0;
        repeat (3) @(negedge clk);
        check("R13", "pipe drive in reset", {31'b0, en_p}, 32'b0);
        check("R13", "flow drive in reset", {31'b0, en_f}, 32'b0);
        check("R13", "pipe data in reset", {14'b0, rd_p}, 32'b0);
        rst_n = 1'b1;
        qp.push_back('0); tp.push_back("R13");
        mon_on = 1;
        cur_tag = "R13"; nop(0); nop(0);

        // early-strobe write, then stepped writes
        cur_tag = "R3"; early_wr(6'h08, 18'h12345);
        cur_tag = "R5";
        cyc('0, 1, 1, 0, SEL, 0, 1, 2'b11, 1, 18'h2A0B1);
        cyc('0, 1, 1, 0, SEL, 0, 1, 2'b11, 1, 18'h3C4D5);
        cyc('0, 1, 1, 0, SEL, 0, 1, 2'b11, 1, 18'h05A6B);
        cur_tag = "R7"; rd_start(6'h08); stp(0); stp(0); stp(0); nop(0);
        cur_tag = "R6"; rd_start(6'h0A); stp(0); stp(0); stp(0); stp(0); nop(0);
        cur_tag = "R5"; rd_start(6'h08); nop(0); stp(0); nop(0); stp(0);
        cur_tag = "R2"; cyc(6'h0B, 1, 0, 1, SEL, 1, 1, 2'b11, 0, 18'h3FFFF); nop(0);

        // late-strobe write: data on the next edge
        cur_tag = "R4"; early_wr(6'h10, 18'h11111);
        cyc(6'h10, 0, 1, 1, SEL, 0, 1, 2'b11, 0, 18'h3FFFF);
        cyc('0, 1, 1, 1, SEL, 0, 1, 2'b11, 1, 18'h2BCDE);
        rd_start(6'h10); nop(0);

        // both strobes low
        cur_tag = "R12"; early_wr(6'h11, 18'h1E1E1);
        cyc(6'h11, 0, 0, 1, SEL, 0, 1, 2'b11, 0, 18'h00F0F);
        nop(0); rd_start(6'h11); nop(0);

        // lane writes and layout
        cur_tag = "R8"; early_wr(6'h20, 18'h3FFFF);
        cyc(6'h20, 1, 0, 1, SEL, 1, 0, 2'b10, 1, 18'h00000);
        rd_start(6'h20); nop(0);
        cyc(6'h20, 1, 0, 1, SEL, 1, 0, 2'b01, 1, 18'h15555);
        rd_start(6'h20); nop(0);
        cur_tag = "R10";
        cyc(6'h20, 1, 0, 1, SEL, 1, 0, 2'b11, 0, 18'h00000);
        cyc(6'h20, 1, 0, 1, SEL, 1, 1, 2'b00, 0, 18'h00000);
        rd_start(6'h20); nop(0);
        cur_tag = "R9";
        cyc(6'h20, 1, 0, 1, SEL, 0, 0, 2'b11, 1, 18'h0ABCD);
        rd_start(6'h20); nop(0);

        // deselected strobes
        cur_tag = "R1";
        cyc(6'h08, 1, 0, 1, 3'b101, 0, 1, 2'b11, 0, 18'h00000);
        stp(0); stp(0);
        cyc(6'h08, 0, 1, 1, 3'b000, 0, 1, 2'b11, 0, 18'h00000);
        cyc('0, 1, 1, 1, SEL, 0, 1, 2'b11, 0, 18'h00000);
        cyc(6'h08, 1, 0, 1, 3'b011, 0, 1, 2'b11, 0, 18'h00000);
        rd_start(6'h08); nop(0); nop(0);

        // output enable gating
        cur_tag = "R11";
        cyc(6'h09, 0, 1, 1, SEL, 1, 1, 2'b11, 1, '0);
        stp(1); stp(1); stp(0); stp(0); nop(1); nop(0);
        nop(0); nop(0);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule